// File: doc/BRIEF.md
# Scatter-Gather Transfer List Sequencer

This block carries out one list-form transfer command. Software places a table of 8-byte entries in local memory and then issues a start with four values: the table's address, the table's length in bytes, the first local-store address, and one upper 32-bit external address. The sequencer reads the entries one at a time, in table order, through a local memory read port. Each entry becomes one sub-transfer request on a downstream transfer port. A request carries the running local address, the full 64-bit external address and the byte count.

Between entries the local address moves forward by the size of the entry just finished. If the result does not fall on a 16-byte boundary, it is rounded up to the next one. An entry can carry a pause flag. When it does, the sequencer waits for that entry's transfer to finish, holds a stall event, and fetches nothing more until software acknowledges the event. This gives software a chance to rewrite later entries before they are read.

A bad table length is refused at the start with an error. A normal run ends with a one-cycle done pulse.

Top module: `dls_list_seq`

## Requirements
- R1: After synchronous reset, busy, done, err, xfer_valid, mem_rd_en and stall_evt are all 0.
- R2: Each entry is a 64-bit read word. Bit 63 is the pause flag, bits 62:32 are the size word and bits 31:0 are the external low address. The request carries xfer_size = size word bits 14:0 and xfer_ea = {cmd_ea_hi, low address}.
- R3: Entries are read in stored order. The first read is at cmd_list_addr with bits 2:0 cleared, and each later read is 8 higher. There is exactly one read per entry, and read data is taken one cycle after mem_rd_en.
- R4: The first request uses cmd_ls_addr. Each later request uses the previous local address plus the previous size, rounded up to a multiple of 16 when it is not one already.
- R5: A request holds xfer_valid with stable fields until xfer_ready. No further entry is read before the accepted request's xfer_done.
- R6: After xfer_done of a flagged entry, stall_evt stays high and no read is issued until stall_ack. The next entry's read starts the cycle after stall_ack.
- R7: done pulses for one cycle, one cycle after the last entry's xfer_done. If that entry is flagged, done instead comes one cycle after stall_ack.
- R8: A start whose length is 0, not a multiple of 8, or above 2048×8 bytes gives done and err together in the next cycle. No read and no request is issued.
- R9: cmd_start is ignored while busy. The running command's addresses and entry count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start pulse for a list command |
| cmd_list_addr | input | 18 | Local address of the entry table |
| cmd_list_len | input | 15 | Table length in bytes |
| cmd_ls_addr | input | 18 | First local-store address |
| cmd_ea_hi | input | 32 | Upper external address used for every entry |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | With done: command refused for its length |
| mem_rd_en | output | 1 | Entry read strobe |
| mem_rd_addr | output | 18 | Entry read address |
| mem_rd_data | input | 64 | Entry data, one cycle after the strobe |
| xfer_valid | output | 1 | Sub-transfer request |
| xfer_ready | input | 1 | Request accepted |
| xfer_ls_addr | output | 18 | Local-store address of the sub-transfer |
| xfer_ea | output | 64 | External address of the sub-transfer |
| xfer_size | output | 15 | Byte count of the sub-transfer |
| xfer_done | input | 1 | Accepted sub-transfer finished |
| stall_evt | output | 1 | Paused after a flagged entry |
| stall_ack | input | 1 | Software release of the pause |

## Verification
The assertions rely on three assumptions about the inputs:
- the read port returns data with a fixed one-cycle latency;
- xfer_done arrives as a single pulse, and only after a request has been accepted;
- stall_ack is pulsed only while a pause is being held.

The bench meets these assumptions with a single responder. The responder models the memory with a registered read and answers every handshake exactly once after a programmable delay. It pulses the acknowledge only after it has seen stall_evt for a chosen number of cycles. Ready delays and pause lengths vary between runs, so each check sees both immediate and drawn-out handshakes.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int ENTRY_BYTES = 8;
    localparam int ENTRY_LG2   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT,
        ST_PAUSE
    } dls_state_e;

    // Layout of one table entry as returned by the read port
    typedef struct packed {
        logic        pause;
        logic [30:0] size_word;
        logic [31:0] ea_lo;
    } dls_entry_t;

endpackage

// File: rtl/dls_len_check.sv
module dls_len_check #(
    parameter int MAX_ELEMS = 2048,
    parameter int LEN_W     = 15,
    parameter int CNT_W     = 12
) (
    input  logic [LEN_W-1:0] len,
    output logic             ok,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned MAX_BYTES = MAX_ELEMS * dls_pkg::ENTRY_BYTES;

    assign ok    = (len != '0)
                && (len[dls_pkg::ENTRY_LG2-1:0] == '0)
                && (32'(len) <= MAX_BYTES);
    assign count = CNT_W'(len >> dls_pkg::ENTRY_LG2);
endmodule

// File: rtl/dls_addr_step.sv
module dls_addr_step #(
    parameter int AW        = 18,
    parameter int SIZE_W    = 15,
    parameter int ALIGN_LG2 = 4
) (
    input  logic [AW-1:0]     cur,
    input  logic [SIZE_W-1:0] size,
    output logic [AW-1:0]     nxt
);
    generate
        if (ALIGN_LG2 == 0) begin : g_plain
            assign nxt = cur + AW'(size);
        end else begin : g_round
            localparam logic [AW-1:0] MASK = AW'((1 << ALIGN_LG2) - 1);
            assign nxt = (cur + AW'(size) + MASK) & ~MASK;
        end
    endgenerate
endmodule

// File: rtl/dls_list_seq.sv
module dls_list_seq #(
    parameter int LS_AW     = 18,
    parameter int SIZE_W    = 15,
    parameter int MAX_ELEMS = 2048,
    parameter int LEN_W     = $clog2(MAX_ELEMS * 8) + 1,
    parameter int ALIGN_LG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [LS_AW-1:0]  cmd_list_addr,
    input  logic [LEN_W-1:0]  cmd_list_len,
    input  logic [LS_AW-1:0]  cmd_ls_addr,
    input  logic [31:0]       cmd_ea_hi,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mem_rd_en,
    output logic [LS_AW-1:0]  mem_rd_addr,
    input  logic [63:0]       mem_rd_data,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [LS_AW-1:0]  xfer_ls_addr,
    output logic [63:0]       xfer_ea,
    output logic [SIZE_W-1:0] xfer_size,
    input  logic              xfer_done,
    output logic              stall_evt,
    input  logic              stall_ack
);
    import dls_pkg::*;

    localparam int CNT_W = $clog2(MAX_ELEMS + 1);
    localparam logic [LS_AW-1:0] BASE_MASK = ~LS_AW'(ENTRY_BYTES - 1);

    dls_state_e        state;
    logic [LS_AW-1:0]  list_ptr;
    logic [LS_AW-1:0]  ls_cur;
    logic [31:0]       ea_hi;
    logic [CNT_W-1:0]  remain;
    dls_entry_t        entry;
    logic              done_q;
    logic              err_q;

    logic              len_ok;
    logic [CNT_W-1:0]  len_count;
    logic [LS_AW-1:0]  ls_next;
    logic [SIZE_W-1:0] cur_size;

    dls_len_check #(
        .MAX_ELEMS (MAX_ELEMS),
        .LEN_W     (LEN_W),
        .CNT_W     (CNT_W)
    ) u_len (
        .len   (cmd_list_len),
        .ok    (len_ok),
        .count (len_count)
    );

    assign cur_size = SIZE_W'(entry.size_word);

    dls_addr_step #(
        .AW        (LS_AW),
        .SIZE_W    (SIZE_W),
        .ALIGN_LG2 (ALIGN_LG2)
    ) u_step (
        .cur  (ls_cur),
        .size (cur_size),
        .nxt  (ls_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            list_ptr <= '0;
            ls_cur   <= '0;
            ea_hi    <= '0;
            remain   <= '0;
            entry    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_start) begin
                        if (len_ok) begin
                            list_ptr <= cmd_list_addr & BASE_MASK;
                            ls_cur   <= cmd_ls_addr;
                            ea_hi    <= cmd_ea_hi;
                            remain   <= len_count;
                            state    <= ST_FETCH;
                        end else begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end
                    end
                end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD: begin
                    entry <= dls_entry_t'(mem_rd_data);
                    state <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (xfer_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (xfer_done) begin
                        ls_cur   <= ls_next;
                        list_ptr <= list_ptr + LS_AW'(ENTRY_BYTES);
                        remain   <= remain - CNT_W'(1);
                        if (entry.pause) begin
                            state <= ST_PAUSE;
                        end else if (remain == CNT_W'(1)) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                ST_PAUSE: begin
                    if (stall_ack) begin
                        if (remain == '0) begin
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            state <= ST_FETCH;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state != ST_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign mem_rd_en    = (state == ST_FETCH);
    assign mem_rd_addr  = list_ptr;
    assign xfer_valid   = (state == ST_ISSUE);
    assign xfer_ls_addr = ls_cur;
    assign xfer_ea      = {ea_hi, entry.ea_lo};
    assign xfer_size    = cur_size;
    assign stall_evt    = (state == ST_PAUSE);

endmodule

// File: rtl/dls_list_seq_chk.sv
module dls_list_seq_chk #(
    parameter int LS_AW  = 18,
    parameter int SIZE_W = 15
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mem_rd_en,
    input logic [LS_AW-1:0]  mem_rd_addr,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [LS_AW-1:0]  xfer_ls_addr,
    input logic [63:0]       xfer_ea,
    input logic [SIZE_W-1:0] xfer_size,
    input logic              stall_evt,
    input logic              stall_ack
);
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_ls_addr)
                                      && $stable(xfer_ea) && $stable(xfer_size));

    a_r6_pause_hold: assert property (@(posedge clk) disable iff (rst)
        stall_evt && !stall_ack |=> stall_evt);

    a_r6_pause_quiet: assert property (@(posedge clk) disable iff (rst)
        stall_evt |-> !mem_rd_en && !xfer_valid);

    a_r8_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !xfer_valid && !mem_rd_en);

    a_r3_rd_aligned: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (mem_rd_addr[2:0] == 3'b000) && !xfer_valid);

    a_r5_no_read_after_accept: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && xfer_ready |=> !mem_rd_en);
endmodule

bind dls_list_seq dls_list_seq_chk #(.LS_AW(LS_AW), .SIZE_W(SIZE_W)) u_chk (.*);

// File: tb/tb_dls_list_seq.sv
`timescale 1ns/1ps
module tb_dls_list_seq;
    localparam int LS_AW  = 18;
    localparam int SIZE_W = 15;
    localparam int LEN_W  = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_start = 1'b0;
    logic [LS_AW-1:0]  cmd_list_addr = '0;
    logic [LEN_W-1:0]  cmd_list_len = '0;
    logic [LS_AW-1:0]  cmd_ls_addr = '0;
    logic [31:0]       cmd_ea_hi = '0;
    logic              busy, done, err, mem_rd_en, xfer_valid, stall_evt;
    logic [LS_AW-1:0]  mem_rd_addr, xfer_ls_addr;
    logic [63:0]       mem_rd_data = '0;
    logic [63:0]       xfer_ea;
    logic [SIZE_W-1:0] xfer_size;
    logic              xfer_ready = 1'b0;
    logic              xfer_done = 1'b0;
    logic              stall_ack = 1'b0;

    always #2.5 clk = ~clk;

    dls_list_seq dut (.*);

    logic [63:0] mem [256];
    always @(posedge clk) mem_rd_data <= mem_rd_en ? mem[mem_rd_addr[10:3]] : 64'h0;

    // Responder and monitor state (written only in the negedge block)
    int negcnt = 0;
    int nrd = 0, nreq = 0, ndone = 0, nstall = 0;
    int stab_viol = 0, fetch_viol = 0, stall_viol = 0;
    int done_neg = 0, done_drive_neg = 0, ack_neg = 0;
    logic last_err = 1'b0;
    logic [LS_AW-1:0]  rd_log [256];
    int                rd_neg [256];
    logic [LS_AW-1:0]  rq_ls [256];
    logic [63:0]       rq_ea [256];
    logic [SIZE_W-1:0] rq_sz [256];
    logic rsp_busy = 1'b0;
    int rsp_cnt = 0, rsp_wait = 0, pcnt = 0, prd_snap = 0;
    logic in_pause = 1'b0;
    logic [LS_AW-1:0]  sn_ls;
    logic [63:0]       sn_ea;
    logic [SIZE_W-1:0] sn_sz;

    // Configuration (written only by the main initial block)
    int rdy_dly = 0, done_dly = 0, ack_dly = 3;

    always @(negedge clk) begin
        negcnt = negcnt + 1;
        xfer_done = 1'b0;
        stall_ack = 1'b0;
        if (mem_rd_en) begin
            rd_log[nrd % 256] = mem_rd_addr;
            rd_neg[nrd % 256] = negcnt;
            nrd = nrd + 1;
        end
        if (rsp_busy) begin
            xfer_ready = 1'b0;
            if (mem_rd_en) fetch_viol = fetch_viol + 1;
            if (rsp_cnt == 0) begin
                xfer_done = 1'b1;
                done_drive_neg = negcnt;
                rsp_busy = 1'b0;
            end else rsp_cnt = rsp_cnt - 1;
        end else if (xfer_valid) begin
            if (rsp_wait == 0) begin
                sn_ls = xfer_ls_addr; sn_ea = xfer_ea; sn_sz = xfer_size;
            end else if (sn_ls != xfer_ls_addr || sn_ea != xfer_ea || sn_sz != xfer_size)
                stab_viol = stab_viol + 1;
            if (rsp_wait >= rdy_dly) begin
                xfer_ready = 1'b1;
                rq_ls[nreq % 256] = xfer_ls_addr;
                rq_ea[nreq % 256] = xfer_ea;
                rq_sz[nreq % 256] = xfer_size;
                nreq = nreq + 1;
                rsp_busy = 1'b1;
                rsp_cnt = done_dly;
                rsp_wait = 0;
            end else rsp_wait = rsp_wait + 1;
        end
        if (stall_evt) begin
            if (!in_pause) begin
                in_pause = 1'b1;
                pcnt = 0;
                prd_snap = nrd;
            end
            pcnt = pcnt + 1;
            if (pcnt == ack_dly) begin
                stall_ack = 1'b1;
                ack_neg = negcnt;
                nstall = nstall + 1;
                if (nrd != prd_snap) stall_viol = stall_viol + 1;
            end
        end else in_pause = 1'b0;
        if (done) begin
            ndone = ndone + 1;
            done_neg = negcnt;
            last_err = err;
        end
    end

    int nchk = 0, nfail = 0;
    logic st_done, st_err, st_busy;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic p, input int sz, input logic [31:0] lo);
        return {p, 31'(sz), lo};
    endfunction

    task automatic start_cmd(input logic [LS_AW-1:0] la, input logic [LEN_W-1:0] ln,
                             input logic [LS_AW-1:0] ls, input logic [31:0] hi);
        @(negedge clk);
        cmd_list_addr = la; cmd_list_len = ln; cmd_ls_addr = ls; cmd_ea_hi = hi;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        st_done = done; st_err = err; st_busy = busy;
    endtask

    task automatic wait_done(input int base, input string tag);
        int t = 0;
        while (ndone == base && t < 3000) begin
            @(negedge clk);
            t = t + 1;
        end
        chk(ndone > base, tag, 64'(ndone - base), 64'(1));
        repeat (2) @(negedge clk);
    endtask

    // {local start, size, expected next local address}
    localparam logic [59:0] VEC [8] = '{
        {20'h00100, 20'h00010, 20'h00110},
        {20'h00100, 20'h00001, 20'h00110},
        {20'h00103, 20'h0000D, 20'h00110},
        {20'h00105, 20'h00004, 20'h00110},
        {20'h00200, 20'h00000, 20'h00200},
        {20'h00208, 20'h00008, 20'h00210},
        {20'h03FF0, 20'h04000, 20'h07FF0},
        {20'h00001, 20'h0001F, 20'h00020}
    };

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk + 1, nfail + 1);
        $finish;
    end

    initial begin
        int b_req, b_rd, b_done, b_st;
        for (int i = 0; i < 256; i++) mem[i] = 64'h0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk({busy, done, err, xfer_valid, mem_rd_en, stall_evt} == 6'b0, "R1 outputs in reset",
            64'({busy, done, err, xfer_valid, mem_rd_en, stall_evt}), 64'h0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk({busy, done, err, xfer_valid, mem_rd_en, stall_evt} == 6'b0, "R1 outputs after reset",
            64'({busy, done, err, xfer_valid, mem_rd_en, stall_evt}), 64'h0);

        // Table walk: R2 fields and R4 local address advance
        for (int i = 0; i < 8; i++) begin
            logic [LS_AW-1:0]  v_ls;
            logic [SIZE_W-1:0] v_sz;
            logic [LS_AW-1:0]  v_exp;
            logic [31:0]       lo;
            v_ls = VEC[i][57:40]; v_sz = VEC[i][34:20]; v_exp = VEC[i][17:0];
            lo = 32'h1000_0000 + 32'(i * 256);
            mem[0] = mk(1'b0, int'(v_sz), lo);
            mem[1] = mk(1'b0, 16, 32'h2000_0000);
            b_req = nreq; b_done = ndone;
            start_cmd('0, 15'd16, v_ls, 32'hA000_0000 + 32'(i));
            wait_done(b_done, "R7 table run finishes");
            chk(nreq - b_req == 2, "R3 two requests", 64'(nreq - b_req), 64'(2));
            chk(rq_ls[b_req % 256] == v_ls, "R4 first local addr", 64'(rq_ls[b_req % 256]), 64'(v_ls));
            chk(rq_ls[(b_req + 1) % 256] == v_exp, "R4 advanced local addr",
                64'(rq_ls[(b_req + 1) % 256]), 64'(v_exp));
            chk(rq_ea[b_req % 256] == {32'hA000_0000 + 32'(i), lo}, "R2 external addr",
                rq_ea[b_req % 256], {32'hA000_0000 + 32'(i), lo});
            chk(rq_sz[b_req % 256] == v_sz, "R2 size field", 64'(rq_sz[b_req % 256]), 64'(v_sz));
        end

        // R3 ordering from an unaligned base, R7 done timing
        mem[8]  = mk(1'b0, 32, 32'hC000_0008);
        mem[9]  = mk(1'b0, 48, 32'hC000_0009);
        mem[10] = {1'b0, 16'h7FFF, 15'd16, 32'hC000_000A};
        b_req = nreq; b_rd = nrd; b_done = ndone;
        start_cmd(18'h00043, 15'd24, 18'h01000, 32'h0000_0055);
        chk(st_busy == 1'b1 && st_done == 1'b0, "R3 good start goes busy", 64'({st_busy, st_done}), 64'h2);
        wait_done(b_done, "R7 three-entry run finishes");
        chk(nrd - b_rd == 3, "R3 one read per entry", 64'(nrd - b_rd), 64'(3));
        for (int k = 0; k < 3; k++)
            chk(rd_log[(b_rd + k) % 256] == LS_AW'(18'h40 + 8 * k), "R3 read address in order",
                64'(rd_log[(b_rd + k) % 256]), 64'(18'h40 + 8 * k));
        chk(rq_ea[(b_req + 2) % 256] == 64'h0000_0055_C000_000A, "R2 third external addr",
            rq_ea[(b_req + 2) % 256], 64'h0000_0055_C000_000A);
        chk(rq_sz[(b_req + 2) % 256] == 15'd16, "R2 size uses low 15 bits",
            64'(rq_sz[(b_req + 2) % 256]), 64'd16);
        chk(rq_ls[(b_req + 2) % 256] == 18'h01050, "R4 third local addr",
            64'(rq_ls[(b_req + 2) % 256]), 64'h1050);
        chk(done_neg - done_drive_neg == 1, "R7 done one cycle after last xfer_done",
            64'(done_neg - done_drive_neg), 64'(1));
        chk(last_err == 1'b0, "R8 no err on good run", 64'(last_err), 64'h0);

        // R5 slow accept and slow completion
        rdy_dly = 3; done_dly = 4;
        mem[0] = mk(1'b0, 64, 32'h0000_1111);
        mem[1] = mk(1'b0, 8, 32'h0000_2222);
        b_req = nreq; b_done = ndone;
        start_cmd('0, 15'd16, 18'h00400, 32'h1);
        wait_done(b_done, "R5 slow run finishes");
        chk(stab_viol == 0, "R5 request stable until ready", 64'(stab_viol), 64'h0);
        chk(fetch_viol == 0, "R5 no read before xfer_done", 64'(fetch_viol), 64'h0);
        chk(nreq - b_req == 2, "R5 request count", 64'(nreq - b_req), 64'(2));
        rdy_dly = 0; done_dly = 0;

        // R6 pause on the first of two entries
        ack_dly = 5;
        mem[0] = mk(1'b1, 16, 32'h0000_3333);
        mem[1] = mk(1'b0, 16, 32'h0000_4444);
        b_req = nreq; b_rd = nrd; b_done = ndone; b_st = nstall;
        start_cmd('0, 15'd16, 18'h00800, 32'h2);
        wait_done(b_done, "R6 paused run finishes");
        chk(nstall - b_st == 1, "R6 one pause", 64'(nstall - b_st), 64'(1));
        chk(stall_viol == 0, "R6 no read during pause", 64'(stall_viol), 64'h0);
        chk(rd_neg[(b_rd + 1) % 256] == ack_neg + 1, "R6 read resumes after ack",
            64'(rd_neg[(b_rd + 1) % 256] - ack_neg), 64'(1));
        chk(nreq - b_req == 2, "R6 both entries issued", 64'(nreq - b_req), 64'(2));

        // R7 pause on the last entry delays done until ack
        mem[0] = mk(1'b1, 32, 32'h0000_5555);
        b_done = ndone; b_st = nstall;
        start_cmd('0, 15'd8, 18'h00900, 32'h3);
        wait_done(b_done, "R7 paused-last run finishes");
        chk(nstall - b_st == 1, "R7 pause on last entry", 64'(nstall - b_st), 64'(1));
        chk(done_neg == ack_neg + 1, "R7 done one cycle after ack",
            64'(done_neg - ack_neg), 64'(1));
        ack_dly = 3;

        // R8 refused lengths
        for (int k = 0; k < 3; k++) begin
            logic [LEN_W-1:0] bad;
            bad = (k == 0) ? 15'd0 : (k == 1) ? 15'd12 : 15'd16392;
            b_req = nreq; b_rd = nrd;
            start_cmd('0, bad, 18'h0, 32'h4);
            chk(st_done && st_err, "R8 done and err next cycle", 64'({st_done, st_err}), 64'h3);
            repeat (4) @(negedge clk);
            chk(nrd == b_rd && nreq == b_req && !busy, "R8 nothing issued",
                64'(nrd - b_rd + nreq - b_req), 64'h0);
        end

        // R9 start while busy is ignored
        done_dly = 8;
        mem[0] = mk(1'b0, 16, 32'h0000_6666);
        mem[1] = mk(1'b0, 16, 32'h0000_7777);
        mem[16] = mk(1'b0, 16, 32'h0000_9999);
        b_req = nreq; b_rd = nrd; b_done = ndone;
        start_cmd('0, 15'd16, 18'h00A00, 32'h0000_00AA);
        repeat (4) @(negedge clk);
        cmd_list_addr = 18'h00080; cmd_list_len = 15'd8; cmd_ls_addr = 18'h00F00;
        cmd_ea_hi = 32'h0000_00BB; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        wait_done(b_done, "R9 run finishes");
        repeat (20) @(negedge clk);
        chk(nreq - b_req == 2, "R9 request count unchanged", 64'(nreq - b_req), 64'(2));
        chk(rq_ea[(b_req + 1) % 256] == 64'h0000_00AA_0000_7777, "R9 upper addr kept",
            rq_ea[(b_req + 1) % 256], 64'h0000_00AA_0000_7777);
        chk(rd_log[(b_rd + 1) % 256] == 18'h00008, "R9 read sequence kept",
            64'(rd_log[(b_rd + 1) % 256]), 64'h8);
        chk(ndone - b_done == 1, "R9 single done", 64'(ndone - b_done), 64'(1));

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule